// File: doc/BRIEF.md
# Four-Lane RAKE Maximum-Ratio Combiner

This block is the demodulation stage of a pulse-based receiver. It runs once acquisition and channel estimation are complete, when the multipath delays and the channel weights are already known. For each payload bit it takes one complex sample per RAKE finger, five fingers in all, with each sample taken at one of the chosen path delays. It weighs each sample by the conjugate of that finger's channel weight and sums the real parts into one metric. A hard sign decision on that metric gives the bit.

Four such combiners work side by side on one shared set of weights. Each clock therefore resolves four bits, and a ready strobe marks them. At a 25 MHz clock this gives 100 Mbps. Choosing the finger samples out of the raw sample stream, and estimating the weights, are done outside this block. The weights arrive through a small write port, one finger per write, while no samples are being presented.

Top module: `rake_mrc4`

## Requirements
- R1: After reset, `bits_out` and `data_rdy` are 0 and every finger weight is zero. A beat presented with zero weights therefore decides every lane as 1.
- R2: When `wt_we` is 1, `wt_idx` is 0 to 4 and `in_valid` is 0, the pair (`wt_i`, `wt_q`) becomes the weight of finger `wt_idx` at that clock edge. The same weight is used by all four lanes.
- R3: A weight write in a cycle where `in_valid` is 1 is ignored. The stored weights stay unchanged.
- R4: A weight write with `wt_idx` of 5 or more is ignored. The stored weights stay unchanged.
- R5: The sample for lane l and finger f sits at bits [(l*5+f)*5 +: 5] of `smp_i` (in-phase part) and of `smp_q` (quadrature part). All samples and weights are signed two's complement values of 5 bits. The lane metric is the sum over the five fingers of (sample_I·w_I + sample_Q·w_Q).
- R6: `bits_out[l]` is 1 when the metric of lane l is at least zero and 0 when it is negative. A metric of exactly zero gives 1.
- R7: `data_rdy` is 1 in the cycle exactly two clocks after a cycle in which `in_valid` was 1, and 0 otherwise. The four decisions for that beat appear on `bits_out` in that same cycle.
- R8: While `data_rdy` is 0, `bits_out` holds the last decisions it issued.
- R9: All input values, including -16 in every sample and every weight, are combined without overflow. The decision matches the exact arithmetic sign.
- R10: Beats on consecutive cycles each produce their own result on consecutive cycles, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_we | input | 1 | Weight write enable |
| wt_idx | input | 3 | Finger index of the write |
| wt_i | input | 5 | In-phase part of the weight |
| wt_q | input | 5 | Quadrature part of the weight |
| in_valid | input | 1 | A beat of samples is present |
| smp_i | input | 100 | In-phase finger samples of all lanes |
| smp_q | input | 100 | Quadrature finger samples of all lanes |
| bits_out | output | 4 | Hard decisions, bit l from lane l |
| data_rdy | output | 1 | `bits_out` carries a new beat |

## Verification
A corrupted weight register shows up only through decisions. It is seen on the first beat whose metric sign depends on that finger, which is two cycles after that beat enters. The bench therefore pairs every weight change with beats chosen close to the zero threshold. A broken valid pipeline shows at once as a strobe with nothing expected in the scoreboard, or as a missing strobe. An error in the sign extension or the accumulator width shows first on the extreme-value beats, where the true sum is near 2560 in magnitude.

// File: rtl/rake_mrc4.sv
module rake_mrc4 #(
  parameter int NLANE = 4,
  parameter int NFING = 5,
  parameter int SW    = 5,
  parameter int WW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wt_we,
  input  logic [$clog2(NFING)-1:0]  wt_idx,
  input  logic [WW-1:0]             wt_i,
  input  logic [WW-1:0]             wt_q,
  input  logic                      in_valid,
  input  logic [NLANE*NFING*SW-1:0] smp_i,
  input  logic [NLANE*NFING*SW-1:0] smp_q,
  output logic [NLANE-1:0]          bits_out,
  output logic                      data_rdy
);
  localparam int IW = $clog2(NFING);
  localparam int PW = SW + WW;
  localparam int FW = PW + 1;
  localparam int MW = FW + $clog2(NFING);

  logic [NFING*WW-1:0] wt_i_q, wt_q_q;
  logic                valid1;
  logic [NLANE-1:0]    dec;

  logic signed [FW-1:0] prod_c [NLANE][NFING];
  logic signed [FW-1:0] part_q [NLANE][NFING];

  wire wt_ok = wt_we && !in_valid;

  for (genvar f = 0; f < NFING; f++) begin : g_wt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wt_i_q[f*WW +: WW] <= '0;
        wt_q_q[f*WW +: WW] <= '0;
      end else if (wt_ok && wt_idx == IW'(f)) begin
        wt_i_q[f*WW +: WW] <= wt_i;
        wt_q_q[f*WW +: WW] <= wt_q;
      end
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    for (genvar f = 0; f < NFING; f++) begin : g_fing
      wire signed [SW-1:0] si = smp_i[(l*NFING+f)*SW +: SW];
      wire signed [SW-1:0] sq = smp_q[(l*NFING+f)*SW +: SW];
      wire signed [WW-1:0] wi = wt_i_q[f*WW +: WW];
      wire signed [WW-1:0] wq = wt_q_q[f*WW +: WW];
      wire signed [PW-1:0] pi = si * wi;
      wire signed [PW-1:0] pq = sq * wq;
      assign prod_c[l][f] = {pi[PW-1], pi} + {pq[PW-1], pq};
    end

    logic signed [MW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int f = 0; f < NFING; f++) acc = acc + MW'(part_q[l][f]);
    end
    assign dec[l] = ~acc[MW-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid1 <= 1'b0;
      for (int l = 0; l < NLANE; l++)
        for (int f = 0; f < NFING; f++) part_q[l][f] <= '0;
    end else begin
      valid1 <= in_valid;
      if (in_valid)
        for (int l = 0; l < NLANE; l++)
          for (int f = 0; f < NFING; f++) part_q[l][f] <= prod_c[l][f];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_rdy <= 1'b0;
      bits_out <= '0;
    end else begin
      data_rdy <= valid1;
      if (valid1) bits_out <= dec;
    end
  end
endmodule

// File: rtl/rake_mrc4_chk.sv
module rake_mrc4_chk #(
  parameter int NLANE = 4,
  parameter int NFING = 5,
  parameter int WW    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wt_we,
  input logic [$clog2(NFING)-1:0] wt_idx,
  input logic                     in_valid,
  input logic [NLANE-1:0]         bits_out,
  input logic                     data_rdy,
  input logic [NFING*WW-1:0]      wt_i_q,
  input logic [NFING*WW-1:0]      wt_q_q
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (data_rdy == $past(in_valid, 2)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !data_rdy) |-> $stable(bits_out));

  assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we && in_valid) |=> ($stable(wt_i_q) && $stable(wt_q_q)));

  assert_bad_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_we && (32'(wt_idx) >= NFING)) |=> ($stable(wt_i_q) && $stable(wt_q_q)));
endmodule

bind rake_mrc4 rake_mrc4_chk #(.NLANE(NLANE), .NFING(NFING), .WW(WW)) u_chk (.*);

// File: tb/sim_rake_mrc4.sv
`timescale 1ns/100ps
module sim_rake_mrc4;
  logic clk = 0, rst_n = 0;
  logic wt_we = 0, in_valid = 0;
  logic [2:0] wt_idx = '0;
  logic [4:0] wt_i = '0, wt_q = '0;
  logic [99:0] smp_i = '0, smp_q = '0;
  logic [3:0] bits_out;
  logic data_rdy;

  rake_mrc4 u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int si [4][5], sq [4][5];
  int mwi [5], mwq [5];
  logic [3:0] exp_q [$];
  string tag_q [$];
  logic [3:0] last_bits = '0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model();
    logic [3:0] e;
    for (int l = 0; l < 4; l++) begin
      int m = 0;
      for (int f = 0; f < 5; f++) m += si[l][f]*mwi[f] + sq[l][f]*mwq[f];
      e[l] = (m >= 0);
    end
    return e;
  endfunction

  task automatic pack();
    for (int l = 0; l < 4; l++)
      for (int f = 0; f < 5; f++) begin
        smp_i[(l*5+f)*5 +: 5] = 5'(si[l][f]);
        smp_q[(l*5+f)*5 +: 5] = 5'(sq[l][f]);
      end
  endtask

  task automatic beat(string tag);
    @(posedge clk); #1;
    wt_we = 0; in_valid = 1; pack();
    exp_q.push_back(model()); tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; wt_we = 0; in_valid = 0;
    end
  endtask

  task automatic wr(int idx, int a, int b, bit with_beat, string tag);
    @(posedge clk); #1;
    wt_we = 1; wt_idx = 3'(idx); wt_i = 5'(a); wt_q = 5'(b);
    if (with_beat) begin
      in_valid = 1; pack();
      exp_q.push_back(model()); tag_q.push_back(tag);
    end else begin
      in_valid = 0;
      if (idx < 5) begin mwi[idx] = a; mwq[idx] = b; end
    end
  endtask

  task automatic set_all(int v);
    for (int l = 0; l < 4; l++) for (int f = 0; f < 5; f++) begin si[l][f] = v; sq[l][f] = v; end
  endtask

  task automatic rnd_samples();
    for (int l = 0; l < 4; l++) for (int f = 0; f < 5; f++) begin
      si[l][f] = int'($urandom_range(31)) - 16; sq[l][f] = int'($urandom_range(31)) - 16;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (data_rdy) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected data_rdy", 1, 0);
        else begin
          logic [3:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(bits_out == e, t, bits_out, e);
        end
        last_bits = bits_out;
      end else begin
        check(bits_out == last_bits, "R8 hold", bits_out, last_bits);
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < 5; f++) begin mwi[f] = 0; mwq[f] = 0; end
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    check(bits_out == 4'd0, "R1 reset bits", bits_out, 0);
    check(data_rdy == 1'b0, "R1 reset rdy", data_rdy, 0);

    // R1: zero weights give metric 0 -> all ones
    rnd_samples(); beat("R1 zero weights");
    @(posedge clk); #1; in_valid = 0;
    @(negedge clk); check(data_rdy == 1'b0, "R7 one cycle after", data_rdy, 0);
    @(negedge clk); check(data_rdy == 1'b1, "R7 two cycles after", data_rdy, 1);
    idle(3);

    // R2 / R6: threshold at exactly zero
    wr(0, 1, 0, 0, "");
    set_all(0);
    si[1][0] = -1; si[2][0] = 1; si[3][0] = -16;
    beat("R6 zero threshold");
    wr(2, 0, -3, 0, "");
    sq[0][2] = 1; sq[1][2] = -1; sq[2][2] = 0; sq[3][2] = 2;
    beat("R2 write applies to all lanes");
    idle(2);

    // R3: write while in_valid is ignored
    wr(0, -5, 7, 1, "R3 beat during write");
    set_all(0); si[0][0] = -1; si[1][0] = 1; sq[2][2] = 1; sq[3][2] = -1;
    beat("R3 weights unchanged");
    // R4: out of range index ignored
    wr(5, -16, -16, 0, ""); wr(7, 15, 15, 0, "");
    beat("R4 weights unchanged");
    idle(2);

    // R9: extremes
    for (int f = 0; f < 5; f++) wr(f, -16, -16, 0, "");
    set_all(-16); beat("R9 max positive");
    set_all(15); beat("R9 max negative");
    for (int l = 0; l < 4; l++) for (int f = 0; f < 5; f++) begin si[l][f] = 15; sq[l][f] = -16; end
    beat("R9 mixed extremes");
    idle(2);

    // R5 / R10: random back-to-back and gapped
    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 0)
        for (int f = 0; f < 5; f++) wr(f, int'($urandom_range(31)) - 16, int'($urandom_range(31)) - 16, 0, "");
      rnd_samples();
      beat((k % 2) ? "R10 back to back" : "R5 random metric");
      if ($urandom_range(3) == 0) idle(1);
    end
    idle(4);
    check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule